// File: doc/BRIEF.md
# Gated-Mode Row Driver Sequencer

This block is the low-voltage control logic of a 32-channel row driver. Each channel owns a gate-on output and a clear output. A serial selection register walks through the channels. Four fast inputs drive the block: the clock, a serial selection bit, a gate strobe and a clear strobe. The last register stage is brought out as a serial output so that several drivers can be chained.

In normal mode each strobe drives the matching output of every selected channel. Raising both strobes together on one clock edge never happens in normal operation, so that combination starts a gated phase. The channels then enter the gated state, with clear held active and gate off, in four groups of eight. Group 0 enters on the entry edge and each further group enters one edge later. This staggering limits the clear current surge.

A mode input chooses what happens during this blind phase. Readout either keeps going, so the selection register shifts and a gate-only strobe still turns on the selected rows, or it pauses, so the register freezes and no row is read out. The phase ends after both strobes have been low on two consecutive edges.

Top module: `gatedRowSeq`

## Requirements
- R1: A synchronous active-high reset clears the selection register, drives every gate-on and clear output and the serial output to 0, and returns the block to normal mode.
- R2: Outside a paused blind phase, every rising edge shifts the selection register by one place towards channel 31, loads the serial input into channel 0, and presents channel 31's bit on the serial output.
- R3: In normal mode, after each edge, channel i drives gate-on = (selected and gate strobe sampled high) and clear = (selected and clear strobe sampled high).
- R4: In normal mode, both strobes sampled high on one edge enter the gated phase on that edge.
- R5: Channel i belongs to group i/8. Group k enters the gated state k edges after the entry edge, in order 0, 1, 2, 3, and at most one group enters per edge.
- R6: A channel in a group that has entered drives clear = 1 and gate-on = 0 unless the override of R7 applies.
- R7: With the mode input at 0 (readout continues), the register keeps shifting during the gated phase. An entered, selected channel drives gate-on = 1 and clear = 0 on edges where only the gate strobe was sampled high.
- R8: With the mode input at 1 (readout paused), the register holds its contents on every edge taken while in the gated phase, and no entered channel is overridden.
- R9: The gated phase ends on the second of two consecutive edges with both strobes sampled low. A single low edge followed by any strobe keeps the phase. On the exit edge the outputs follow the normal-mode rule.
- R10: During the gated phase, channels in groups that have not yet entered drive gate-on = 0 and clear = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast control clock |
| rst | input | 1 | Synchronous active-high reset |
| serIn | input | 1 | Serial selection bit shifted into channel 0 |
| gateStb | input | 1 | Gate strobe |
| clearStb | input | 1 | Clear strobe |
| holdReadout | input | 1 | 1 pauses readout during the blind phase, 0 keeps it running |
| gateOn | output | 32 | Per-channel gate-on control |
| clearOn | output | 32 | Per-channel clear control |
| serOut | output | 1 | Last selection stage, for chaining |

## Verification
Every output reflects the inputs sampled on the previous rising edge, so each result is due one edge after its stimulus. Group k shows the gated state k edges after the entry edge. Exit is visible after the second low edge. The bench drives inputs on the falling edge, advances its behavioural model on the rising edge, and compares all outputs on the next falling edge, so each comparison lands exactly one edge after its stimulus.

// File: rtl/rowSeqPkg.sv
package rowSeqPkg;
  localparam int CH_COUNT    = 32;
  localparam int GROUP_SIZE  = 8;
  localparam int GROUP_COUNT = CH_COUNT / GROUP_SIZE;

  // Strobes from the phase controller to the channel datapath
  typedef struct packed {
    logic                   gated;    // gated phase active
    logic [GROUP_COUNT-1:0] groupIn;  // thermometer of groups that have entered
    logic                   gateQ;    // sampled gate strobe
    logic                   clearQ;   // sampled clear strobe
    logic                   holdQ;    // sampled readout-pause mode
    logic                   freeze;   // hold the selection register this edge
  } seqCtl_t;
endpackage

// File: rtl/rowSeqCtrl.sv
module rowSeqCtrl
  import rowSeqPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    gateStb,
  input  logic    clearStb,
  input  logic    holdReadout,
  output seqCtl_t ctl
);
  localparam int G = GROUP_COUNT;

  logic         gatedQ;
  logic [G-1:0] groupQ;
  logic         lowQ;
  logic         gateQ, clearQ, holdQ;
  logic         bothHigh, bothLow, exitNow;

  assign bothHigh = gateStb & clearStb;
  assign bothLow  = ~gateStb & ~clearStb;
  assign exitNow  = gatedQ & bothLow & lowQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      gatedQ <= 1'b0;
      groupQ <= '0;
      lowQ   <= 1'b0;
      gateQ  <= 1'b0;
      clearQ <= 1'b0;
      holdQ  <= 1'b0;
    end else begin
      gateQ  <= gateStb;
      clearQ <= clearStb;
      holdQ  <= holdReadout;
      if (!gatedQ) begin
        lowQ <= 1'b0;
        if (bothHigh) begin
          gatedQ <= 1'b1;
          groupQ <= G'(1);
        end
      end else if (exitNow) begin
        gatedQ <= 1'b0;
        groupQ <= '0;
        lowQ   <= 1'b0;
      end else begin
        groupQ <= {groupQ[G-2:0], 1'b1};
        lowQ   <= bothLow;
      end
    end
  end

  assign ctl.gated   = gatedQ;
  assign ctl.groupIn = groupQ;
  assign ctl.gateQ   = gateQ;
  assign ctl.clearQ  = clearQ;
  assign ctl.holdQ   = holdQ;
  assign ctl.freeze  = gatedQ & holdReadout;

  AST_ENTRY_GROUP0: assert property (@(posedge clk) disable iff (rst)
    (!gatedQ && gateStb && clearStb) |=> (gatedQ && groupQ == G'(1))); // R4
  AST_STAGGER_STEP: assert property (@(posedge clk) disable iff (rst)
    (gatedQ && !(bothLow && lowQ)) |=> (groupQ == {$past(groupQ[G-2:0]), 1'b1})); // R5
  AST_EXIT_TWO_LOW: assert property (@(posedge clk) disable iff (rst)
    (gatedQ && bothLow && lowQ) |=> (!gatedQ && groupQ == '0)); // R9
  AST_NO_EARLY_EXIT: assert property (@(posedge clk) disable iff (rst)
    (gatedQ && !(bothLow && lowQ)) |=> gatedQ); // R9
endmodule

// File: rtl/rowSeqPath.sv
module rowSeqPath
  import rowSeqPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  seqCtl_t             ctl,
  output logic [CH_COUNT-1:0] gateOn,
  output logic [CH_COUNT-1:0] clearOn,
  output logic                serOut
);
  localparam int N  = CH_COUNT;
  localparam int GS = GROUP_SIZE;

  logic [N-1:0] selQ;

  always_ff @(posedge clk) begin
    if (rst)              selQ <= '0;
    else if (!ctl.freeze) selQ <= {selQ[N-2:0], serIn};
  end

  assign serOut = selQ[N-1];

  for (genvar g = 0; g < GROUP_COUNT; g++) begin : gGroup
    for (genvar c = 0; c < GS; c++) begin : gChan
      localparam int IDX = g * GS + c;
      logic ovr;
      assign ovr = ~ctl.holdQ & selQ[IDX] & ctl.gateQ & ~ctl.clearQ;
      assign gateOn[IDX]  = ctl.gated ? (ctl.groupIn[g] & ovr)  : (selQ[IDX] & ctl.gateQ);
      assign clearOn[IDX] = ctl.gated ? (ctl.groupIn[g] & ~ovr) : (selQ[IDX] & ctl.clearQ);
    end

    AST_GROUP_IDLE: assert property (@(posedge clk) disable iff (rst)
      (ctl.gated && !ctl.groupIn[g]) |-> (gateOn[g*GS +: GS] == '0 && clearOn[g*GS +: GS] == '0)); // R10
  end

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctl.freeze |=> $stable(selQ)); // R8
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    !ctl.freeze |=> (selQ[N-1:1] == $past(selQ[N-2:0]))); // R2
endmodule

// File: rtl/gatedRowSeq.sv
module gatedRowSeq
  import rowSeqPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                serIn,
  input  logic                gateStb,
  input  logic                clearStb,
  input  logic                holdReadout,
  output logic [CH_COUNT-1:0] gateOn,
  output logic [CH_COUNT-1:0] clearOn,
  output logic                serOut
);
  seqCtl_t ctl;

  rowSeqCtrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .gateStb     (gateStb),
    .clearStb    (clearStb),
    .holdReadout (holdReadout),
    .ctl         (ctl)
  );

  rowSeqPath uPath (
    .clk     (clk),
    .rst     (rst),
    .serIn   (serIn),
    .ctl     (ctl),
    .gateOn  (gateOn),
    .clearOn (clearOn),
    .serOut  (serOut)
  );

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    ((gateOn & clearOn) == '0)); // R6
endmodule

// File: tb/sim_gatedRowSeq.sv
module sim_gatedRowSeq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serIn = 1'b0, gateStb = 1'b0, clearStb = 1'b0, holdReadout = 1'b0;
  logic [31:0] gateOn, clearOn;
  logic serOut;

  always #5 clk = ~clk;

  gatedRowSeq u0 (
    .clk(clk), .rst(rst), .serIn(serIn), .gateStb(gateStb), .clearStb(clearStb),
    .holdReadout(holdReadout), .gateOn(gateOn), .clearOn(clearOn), .serOut(serOut)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  bit mSel[32];
  bit mGated;
  int mStage;
  int mLowRun;
  bit mG, mC, mH;

  task automatic compare(input string tag);
    logic [31:0] eG, eC;
    for (int i = 0; i < 32; i++) begin
      bit entered, ovr;
      entered = (i / 8) < mStage;
      ovr = !mH && mSel[i] && mG && !mC;
      if (mGated) begin
        eG[i] = entered && ovr;
        eC[i] = entered && !ovr;
      end else begin
        eG[i] = mSel[i] && mG;
        eC[i] = mSel[i] && mC;
      end
    end
    checks += 3;
    if (gateOn !== eG) begin
      fails++;
      $display("FAIL %s gateOn actual=%h expected=%h", tag, gateOn, eG);
    end
    if (clearOn !== eC) begin
      fails++;
      $display("FAIL %s clearOn actual=%h expected=%h", tag, clearOn, eC);
    end
    if (serOut !== mSel[31]) begin
      fails++;
      $display("FAIL %s serOut actual=%b expected=%b", tag, serOut, mSel[31]);
    end
  endtask

  task automatic doReset(input string tag);
    rst = 1'b1;
    serIn = 1'b0; gateStb = 1'b0; clearStb = 1'b0; holdReadout = 1'b0;
    @(posedge clk);
    for (int i = 0; i < 32; i++) mSel[i] = 0;
    mGated = 0; mStage = 0; mLowRun = 0; mG = 0; mC = 0; mH = 0;
    @(negedge clk);
    compare(tag);
    rst = 1'b0;
  endtask

  task automatic step(input bit si, input bit g, input bit c, input bit m, input string tag);
    serIn = si; gateStb = g; clearStb = c; holdReadout = m;
    @(posedge clk);
    if (!(mGated && m)) begin
      for (int i = 31; i > 0; i--) mSel[i] = mSel[i-1];
      mSel[0] = si;
    end
    if (!mGated) begin
      mLowRun = 0;
      if (g && c) begin
        mGated = 1;
        mStage = 1;
      end
    end else begin
      if (!g && !c) mLowRun++;
      else mLowRun = 0;
      if (mLowRun == 2) begin
        mGated = 0; mStage = 0; mLowRun = 0;
      end else if (mStage < 4) begin
        mStage++;
      end
    end
    mG = g; mC = c; mH = m;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset("R1");
    doReset("R1");

    // R2: plain shifting, pattern walks out on serOut
    for (int k = 0; k < 40; k++) step((k % 3) == 0, 0, 0, 0, "R2");

    // R3: normal mode strobes on the selected channels
    for (int k = 0; k < 4; k++) step(k[0], 1, 0, 0, "R3");
    for (int k = 0; k < 4; k++) step(1, 0, 1, 0, "R3");
    for (int k = 0; k < 6; k++) step(k[1], k[0], !k[0], 0, "R3");

    // gated phase with readout continuing
    step(1, 1, 1, 0, "R4");
    step(0, 1, 0, 0, "R5/R10/R7");
    step(1, 1, 0, 0, "R5/R10/R7");
    step(0, 1, 0, 0, "R5/R7");
    step(1, 1, 0, 0, "R7");
    step(0, 0, 1, 0, "R6");
    step(1, 1, 1, 0, "R6");
    step(0, 0, 0, 0, "R9");
    step(1, 1, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");
    step(1, 1, 0, 0, "R3");
    step(0, 0, 1, 0, "R3");

    // gated phase with readout paused
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, "R2");
    step(1, 1, 1, 1, "R4");
    for (int k = 0; k < 5; k++) step(k[0], 1, 0, 1, "R8");
    step(0, 0, 1, 1, "R8/R6");
    step(0, 0, 0, 1, "R9");
    step(1, 0, 0, 1, "R9");
    for (int k = 0; k < 8; k++) step(k[0], 1, 0, 0, "R2");

    // reset in the middle of a gated phase
    step(0, 1, 1, 0, "R4");
    step(0, 0, 1, 0, "R5");
    doReset("R1");
    step(0, 1, 0, 0, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule